// File: doc/BRIEF.md
# Indirect Channel Configuration Register Port

This block holds the per-channel configuration of a two-channel disk interface controller and gives the host access to it through just two locations: a byte-wide pointer and a word-wide data port. The pointer names a bank (primary or secondary channel) and one of seven register slots. A data-port write lands in the slot the pointer names, and a data-port read returns it. If the pointer's auto-advance flag is set, the slot number steps after every data-port access, so a driver can program a whole bank with one pointer write followed by a burst of data writes.

Each bank holds the command-block and control-block base addresses, a general configuration byte, two timing bytes (data port and command port), and a write-only read-ahead setup. The read-ahead setup consists of a 10-bit count split across two slots, an enable bit and a self-clearing FIFO-clear strobe. Every stored value is exported continuously to the rest of the controller, with the DMA-enable and device-reset bits of the general byte broken out as single signals.

The host side is a plain synchronous strobe interface. Writes take effect at the clock edge on which their strobe is high. Read data follows the current pointer combinationally and is valid while the read strobe is high. A read and a write are not issued to the data port in the same cycle.

Top module: `cfgport_top`

## Requirements
- R1: After reset, bank 0 holds command base 0x1F0 and control base 0x3F6, and bank 1 holds 0x170 and 0x376. Both banks hold general byte 0x01, data timing 0xF5, command timing 0xDE, read-ahead count 0 and read-ahead enable 0. The pointer resets to 0x00, and both FIFO-clear strobes are low.
- R2: A pointer write stores the full byte, which then reads back on `ptr_rdata`. Bits 2..0 are the slot index, bit 3 is the bank (0 primary, 1 secondary) and bit 7 is auto-advance. When a pointer write and a data access fall in the same cycle, the data access uses the old pointer, and the newly written byte wins over any advance.
- R3: A data write to slot 0 (command base) or slot 4 (control base) stores all 16 bits of `dat_wdata` in the bank selected by pointer bit 3 only, and a read of that slot returns those 16 bits.
- R4: A data write to slot 1 (general), slot 5 (data timing) or slot 6 (command timing) stores only bits 7..0 of `dat_wdata`, and a read returns the byte zero-extended to 16 bits.
- R5: Slots 2 and 3 are write-only and read as zero. The exported read-ahead count is {slot 3 bits 1..0, slot 2 bits 7..0}, and the read-ahead enable is slot 3 bit 7.
- R6: A data write to slot 3 with bit 6 set raises that bank's `fifo_clr_o` for exactly the one cycle after the write edge. The bit is not stored.
- R7: Slot 7 reads as zero, and a write to it changes no exported register.
- R8: With pointer bit 7 set, every data read or write advances the index after the access, going from 6 (or 7) to 0 and from n to n+1 otherwise. With bit 7 clear, the pointer holds.
- R9: `dma_en_o` follows bit 7 and `drv_rst_o` follows bit 6 of each bank's general byte.
- R10: A data read changes no exported register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write byte |
| ptr_rdata | output | 8 | Current pointer value |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write word |
| dat_rdata | output | 16 | Data-port read word for the current pointer |
| cmd_base_o | output | 2x16 | Command-block base, per bank |
| ctl_base_o | output | 2x16 | Control-block base, per bank |
| gen_cfg_o | output | 2x8 | General configuration byte, per bank |
| dma_en_o | output | 2 | DMA enable, per bank |
| drv_rst_o | output | 2 | Device reset drive, per bank |
| ra_count_o | output | 2x10 | Read-ahead count, per bank |
| ra_en_o | output | 2 | Read-ahead enable, per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO-clear strobe, per bank |
| data_tim_o | output | 2x8 | Data-port timing byte, per bank |
| cmd_tim_o | output | 2x8 | Command-port timing byte, per bank |

## Verification
A directed burst with auto-advance writes all seven slots of one bank in a row and then reads them back. This separates correct wrap from 6 to 0 from a wrap through 7, and tells a full-word slot from a byte slot. Writes with distinct values go to the other bank, which exposes any bank-select leak, and a write to slot 7 and reads of the write-only slots show whether state is touched. Random mixes of pointer writes (both banks, advance on and off), data writes and reads, with some pointer writes landing in the same cycle as a data access, tell old-pointer-use and write-priority apart from the reverse ordering.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 7;
    localparam int RA_W     = 10;
    localparam int NUM_CH   = 2;
    localparam int RA_HI_W  = RA_W - BYTE_W;

    typedef enum logic [IDX_W-1:0] {
        SLOT_CMD_BASE = 3'd0,
        SLOT_GENERAL  = 3'd1,
        SLOT_RA_LOW   = 3'd2,
        SLOT_RA_CFG   = 3'd3,
        SLOT_CTL_BASE = 3'd4,
        SLOT_DATA_TIM = 3'd5,
        SLOT_CMD_TIM  = 3'd6,
        SLOT_UNUSED   = 3'd7
    } slot_e;

    typedef struct packed {
        logic             autoinc;
        logic [2:0]       spare;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    typedef struct packed {
        logic [DATA_W-1:0] cmd_base;
        logic [DATA_W-1:0] ctl_base;
        logic [BYTE_W-1:0] general;
        logic [RA_W-1:0]   ra_count;
        logic              ra_en;
        logic [BYTE_W-1:0] data_tim;
        logic [BYTE_W-1:0] cmd_tim;
    } bank_t;

    localparam int GEN_DMA_BIT   = 7;
    localparam int GEN_RST_BIT   = 6;
    localparam int RA_EN_BIT     = 7;
    localparam int RA_FLUSH_BIT  = 6;

    function automatic bank_t bank_defaults(input logic secondary);
        bank_t b;
        b.cmd_base = secondary ? 16'h0170 : 16'h01F0;
        b.ctl_base = secondary ? 16'h0376 : 16'h03F6;
        b.general  = 8'h01;
        b.ra_count = '0;
        b.ra_en    = 1'b0;
        b.data_tim = 8'hF5;
        b.cmd_tim  = 8'hDE;
        return b;
    endfunction

    function automatic logic [IDX_W-1:0] advance_idx(input logic [IDX_W-1:0] idx);
        if (idx >= IDX_W'(NUM_REGS - 1))
            return '0;
        return idx + 1'b1;
    endfunction

endpackage

// File: rtl/cfgport_ptr.sv
module cfgport_ptr
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              step,
    output ptr_t              ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= ptr_t'(load_val);
        end else if (step && ptr.autoinc) begin
            ptr.idx <= advance_idx(ptr.idx);
        end
    end

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
    import cfgport_pkg::*;
#(
    parameter bit SECONDARY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output bank_t             regs,
    output logic [DATA_W-1:0] rdata,
    output logic              flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= bank_defaults(SECONDARY);
            flush <= 1'b0;
        end else begin
            flush <= 1'b0;
            if (wr_en) begin
                case (slot_e'(idx))
                    SLOT_CMD_BASE: regs.cmd_base <= wdata;
                    SLOT_GENERAL:  regs.general  <= wdata[BYTE_W-1:0];
                    SLOT_RA_LOW:   regs.ra_count[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
                    SLOT_RA_CFG: begin
                        regs.ra_count[RA_W-1:BYTE_W] <= wdata[RA_HI_W-1:0];
                        regs.ra_en <= wdata[RA_EN_BIT];
                        flush      <= wdata[RA_FLUSH_BIT];
                    end
                    SLOT_CTL_BASE: regs.ctl_base <= wdata;
                    SLOT_DATA_TIM: regs.data_tim <= wdata[BYTE_W-1:0];
                    SLOT_CMD_TIM:  regs.cmd_tim  <= wdata[BYTE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (slot_e'(idx))
            SLOT_CMD_BASE: rdata = regs.cmd_base;
            SLOT_GENERAL:  rdata = {{(DATA_W-BYTE_W){1'b0}}, regs.general};
            SLOT_CTL_BASE: rdata = regs.ctl_base;
            SLOT_DATA_TIM: rdata = {{(DATA_W-BYTE_W){1'b0}}, regs.data_tim};
            SLOT_CMD_TIM:  rdata = {{(DATA_W-BYTE_W){1'b0}}, regs.cmd_tim};
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ptr_wr,
    input  logic [BYTE_W-1:0]             ptr_wdata,
    output logic [BYTE_W-1:0]             ptr_rdata,
    input  logic                          dat_wr,
    input  logic                          dat_rd,
    input  logic [DATA_W-1:0]             dat_wdata,
    output logic [DATA_W-1:0]             dat_rdata,
    output logic [NUM_CH-1:0][DATA_W-1:0] cmd_base_o,
    output logic [NUM_CH-1:0][DATA_W-1:0] ctl_base_o,
    output logic [NUM_CH-1:0][BYTE_W-1:0] gen_cfg_o,
    output logic [NUM_CH-1:0]             dma_en_o,
    output logic [NUM_CH-1:0]             drv_rst_o,
    output logic [NUM_CH-1:0][RA_W-1:0]   ra_count_o,
    output logic [NUM_CH-1:0]             ra_en_o,
    output logic [NUM_CH-1:0]             fifo_clr_o,
    output logic [NUM_CH-1:0][BYTE_W-1:0] data_tim_o,
    output logic [NUM_CH-1:0][BYTE_W-1:0] cmd_tim_o
);

    ptr_t                          ptr;
    logic [NUM_CH-1:0][DATA_W-1:0] bank_rdata;

    cfgport_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_wr),
        .load_val (ptr_wdata),
        .step     (dat_wr | dat_rd),
        .ptr      (ptr)
    );

    assign ptr_rdata = ptr;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
        bank_t regs;

        cfgport_bank #(.SECONDARY(ch != 0)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (dat_wr && (ptr.bank == 1'(ch))),
            .idx   (ptr.idx),
            .wdata (dat_wdata),
            .regs  (regs),
            .rdata (bank_rdata[ch]),
            .flush (fifo_clr_o[ch])
        );

        assign cmd_base_o[ch] = regs.cmd_base;
        assign ctl_base_o[ch] = regs.ctl_base;
        assign gen_cfg_o[ch]  = regs.general;
        assign dma_en_o[ch]   = regs.general[GEN_DMA_BIT];
        assign drv_rst_o[ch]  = regs.general[GEN_RST_BIT];
        assign ra_count_o[ch] = regs.ra_count;
        assign ra_en_o[ch]    = regs.ra_en;
        assign data_tim_o[ch] = regs.data_tim;
        assign cmd_tim_o[ch]  = regs.cmd_tim;
    end

    assign dat_rdata = bank_rdata[ptr.bank];

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
    import cfgport_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          ptr_wr,
    input logic [BYTE_W-1:0]             ptr_wdata,
    input logic [BYTE_W-1:0]             ptr_rdata,
    input logic                          dat_wr,
    input logic                          dat_rd,
    input logic [DATA_W-1:0]             dat_wdata,
    input logic [DATA_W-1:0]             dat_rdata,
    input logic [NUM_CH-1:0][DATA_W-1:0] cmd_base_o,
    input logic [NUM_CH-1:0][DATA_W-1:0] ctl_base_o,
    input logic [NUM_CH-1:0][BYTE_W-1:0] gen_cfg_o,
    input logic [NUM_CH-1:0]             dma_en_o,
    input logic [NUM_CH-1:0]             drv_rst_o,
    input logic [NUM_CH-1:0][RA_W-1:0]   ra_count_o,
    input logic [NUM_CH-1:0]             ra_en_o,
    input logic [NUM_CH-1:0]             fifo_clr_o,
    input logic [NUM_CH-1:0][BYTE_W-1:0] data_tim_o,
    input logic [NUM_CH-1:0][BYTE_W-1:0] cmd_tim_o
);

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_wr |=> ptr_rdata == $past(ptr_wdata));

    // R8
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!ptr_wr && (dat_wr || dat_rd) && ptr_rdata[7] && ptr_rdata[2:0] >= 3'd6)
        |=> ptr_rdata[2:0] == 3'd0);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ptr_wr && !ptr_rdata[7]) |=> $stable(ptr_rdata));

    // R5
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && (ptr_rdata[2:0] == 3'd2 || ptr_rdata[2:0] == 3'd3)) |-> dat_rdata == '0);

    // R7
    slot7_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && ptr_rdata[2:0] == 3'd7) |-> dat_rdata == '0);

    // R7
    slot7_write_none_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && ptr_rdata[2:0] == 3'd7) |=>
        ($stable(cmd_base_o) && $stable(ctl_base_o) && $stable(gen_cfg_o) &&
         $stable(ra_count_o) && $stable(ra_en_o) && $stable(data_tim_o) && $stable(cmd_tim_o)));

    // R10
    read_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && !dat_wr) |=>
        ($stable(cmd_base_o) && $stable(ctl_base_o) && $stable(gen_cfg_o) &&
         $stable(ra_count_o) && $stable(ra_en_o) && $stable(data_tim_o) && $stable(cmd_tim_o)));

    // R6
    flush0_src_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr_o[0] |-> $past(dat_wr && ptr_rdata[3] == 1'b0 &&
                                ptr_rdata[2:0] == 3'd3 && dat_wdata[6]));

    // R6
    flush1_src_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr_o[1] |-> $past(dat_wr && ptr_rdata[3] == 1'b1 &&
                                ptr_rdata[2:0] == 3'd3 && dat_wdata[6]));

    // R9
    dma_bit_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en_o == {gen_cfg_o[1][7], gen_cfg_o[0][7]} &&
        drv_rst_o == {gen_cfg_o[1][6], gen_cfg_o[0][6]});

endmodule

bind cfgport_top cfgport_chk u_chk (.*);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              ptr_wr;
    logic [7:0]        ptr_wdata;
    logic [7:0]        ptr_rdata;
    logic              dat_wr;
    logic              dat_rd;
    logic [15:0]       dat_wdata;
    logic [15:0]       dat_rdata;
    logic [1:0][15:0]  cmd_base_o;
    logic [1:0][15:0]  ctl_base_o;
    logic [1:0][7:0]   gen_cfg_o;
    logic [1:0]        dma_en_o;
    logic [1:0]        drv_rst_o;
    logic [1:0][9:0]   ra_count_o;
    logic [1:0]        ra_en_o;
    logic [1:0]        fifo_clr_o;
    logic [1:0][7:0]   data_tim_o;
    logic [1:0][7:0]   cmd_tim_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgport_top dut (.*);

    int checks = 0;
    int errors = 0;

    logic [15:0] m_cmd [2];
    logic [15:0] m_ctl [2];
    logic [7:0]  m_gen [2];
    logic [9:0]  m_ra  [2];
    logic        m_rae [2];
    logic [7:0]  m_dt  [2];
    logic [7:0]  m_ct  [2];
    logic [1:0]  m_flush;
    logic [7:0]  m_ptr;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = c ? 16'h0170 : 16'h01F0;
            m_ctl[c] = c ? 16'h0376 : 16'h03F6;
            m_gen[c] = 8'h01;
            m_ra[c]  = '0;
            m_rae[c] = 1'b0;
            m_dt[c]  = 8'hF5;
            m_ct[c]  = 8'hDE;
        end
        m_flush = '0;
        m_ptr   = '0;
    endtask

    function automatic logic [15:0] model_read(input logic b, input logic [2:0] i);
        case (i)
            3'd0: return m_cmd[b];
            3'd1: return {8'h00, m_gen[b]};
            3'd4: return m_ctl[b];
            3'd5: return {8'h00, m_dt[b]};
            3'd6: return {8'h00, m_ct[b]};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] i);
        case (i)
            3'd0, 3'd4:       return "R3";
            3'd1, 3'd5, 3'd6: return "R4";
            3'd2, 3'd3:       return "R5";
            default:          return "R7";
        endcase
    endfunction

    task automatic compare_all(input string over);
        for (int c = 0; c < 2; c++) begin
            chk(over != "" ? over : "R3", "cmd_base", 32'(cmd_base_o[c]), 32'(m_cmd[c]));
            chk(over != "" ? over : "R3", "ctl_base", 32'(ctl_base_o[c]), 32'(m_ctl[c]));
            chk(over != "" ? over : "R4", "gen_cfg",  32'(gen_cfg_o[c]),  32'(m_gen[c]));
            chk(over != "" ? over : "R4", "data_tim", 32'(data_tim_o[c]), 32'(m_dt[c]));
            chk(over != "" ? over : "R4", "cmd_tim",  32'(cmd_tim_o[c]),  32'(m_ct[c]));
            chk(over != "" ? over : "R5", "ra_count", 32'(ra_count_o[c]), 32'(m_ra[c]));
            chk(over != "" ? over : "R5", "ra_en",    32'(ra_en_o[c]),    32'(m_rae[c]));
            chk(over != "" ? over : "R6", "fifo_clr", 32'(fifo_clr_o[c]), 32'(m_flush[c]));
            chk(over != "" ? over : "R9", "dma_en",   32'(dma_en_o[c]),   32'(m_gen[c][7]));
            chk(over != "" ? over : "R9", "drv_rst",  32'(drv_rst_o[c]),  32'(m_gen[c][6]));
        end
        chk(over != "" ? over : "R8", "pointer", 32'(ptr_rdata), 32'(m_ptr));
    endtask

    // called just after a falling edge
    task automatic bus_op(input logic pw, input logic [7:0] pwd,
                          input logic dw, input logic dr, input logic [15:0] dwd);
        logic b;
        logic [2:0] i;
        b = m_ptr[3];
        i = m_ptr[2:0];
        ptr_wr    = pw;
        ptr_wdata = pwd;
        dat_wr    = dw;
        dat_rd    = dr;
        dat_wdata = dwd;
        #1;
        if (dr) chk(read_tag(i), "dat_rdata", 32'(dat_rdata), 32'(model_read(b, i)));
        @(posedge clk);
        @(negedge clk);
        ptr_wr = 1'b0;
        dat_wr = 1'b0;
        dat_rd = 1'b0;
        m_flush = '0;
        if (dw) begin
            case (i)
                3'd0: m_cmd[b] = dwd;
                3'd1: m_gen[b] = dwd[7:0];
                3'd2: m_ra[b][7:0] = dwd[7:0];
                3'd3: begin
                    m_ra[b][9:8] = dwd[1:0];
                    m_rae[b]     = dwd[7];
                    m_flush[b]   = dwd[6];
                end
                3'd4: m_ctl[b] = dwd;
                3'd5: m_dt[b]  = dwd[7:0];
                3'd6: m_ct[b]  = dwd[7:0];
                default: ;
            endcase
        end
        if (pw) m_ptr = pwd;
        else if ((dw || dr) && m_ptr[7])
            m_ptr[2:0] = (m_ptr[2:0] >= 3'd6) ? 3'd0 : m_ptr[2:0] + 3'd1;
        compare_all(pw && (dw || dr) ? "R2" : "");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        ptr_wr = 0; dat_wr = 0; dat_rd = 0; ptr_wdata = 0; dat_wdata = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        compare_all("R1");

        // R2 pointer byte readback, R8 burst with auto-advance and wrap
        bus_op(1, 8'h80, 0, 0, 16'h0);
        for (int k = 0; k < 7; k++)
            bus_op(0, 8'h0, 1, 0, 16'hA500 + 16'(k * 16'h1111));
        chk("R8", "wrapped index", 32'(ptr_rdata[2:0]), 32'd0);
        for (int k = 0; k < 8; k++)
            bus_op(0, 8'h0, 0, 1, 16'h0);

        // R3 other bank untouched, full-word store on secondary
        bus_op(1, 8'h08, 0, 0, 16'h0);
        bus_op(0, 8'h0, 1, 0, 16'hBEEF);
        bus_op(0, 8'h0, 0, 1, 16'h0);

        // R9 general byte bits on secondary
        bus_op(1, 8'h09, 0, 0, 16'h0);
        bus_op(0, 8'h0, 1, 0, 16'h12C1);
        // R6 FIFO-clear strobe on primary, then no repeat
        bus_op(1, 8'h03, 0, 0, 16'h0);
        bus_op(0, 8'h0, 1, 0, 16'hFFC3);
        bus_op(0, 8'h0, 0, 1, 16'h0);
        // R7 slot 7 write and read, with advance from 7 to 0
        bus_op(1, 8'h8F, 0, 0, 16'h0);
        bus_op(0, 8'h0, 1, 0, 16'hFFFF);
        chk("R7", "index after slot 7", 32'(ptr_rdata[2:0]), 32'd0);
        bus_op(1, 8'h0F, 0, 0, 16'h0);
        bus_op(0, 8'h0, 0, 1, 16'h0);
        // R2 pointer write together with a data write
        bus_op(1, 8'h84, 1, 0, 16'h7777);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic pw, dw, dr;
            r  = int'($urandom % 8);
            pw = (r < 2) || (r == 7);
            dw = (r >= 2 && r < 5) || (r == 7 && $urandom % 2 == 1);
            dr = (r == 5 || r == 6);
            bus_op(pw, 8'($urandom), dw, dr, 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule